// File: doc/BRIEF.md
# Carry-Save Multi-Operand Adder Tree

This block adds N unsigned operands of a common width in one combinational pass. Levels of 3:2 compressors first reduce the operand set to two vectors. A single carry-propagate adder then turns that pair into the final sum. All arithmetic wraps modulo 2^WIDTH.

The layout of the tree is fixed at elaboration by a schedule that tracks the depth of every operand. Inputs start at depth 0, and each compressor output sits one level deeper than its deepest input. At a given level, only the operands that have already reached that level are gathered into triples. The triples are taken in list order. The compressor outputs (sum before carry) come first in the next list, then any ready operands left over, then the operands still waiting. Reduction stops once two operands or fewer remain. The block also reports the number of compressors and the depth of the tree as constants, so a designer can judge the cost of a given N.

The block suits accumulation of partial products, multi-input sums in datapaths, and any place where several additions would otherwise chain one after another.

Top module: `csa_reduce_tree`

## Requirements
- R1: `total_o` equals the sum of all N operands modulo 2^WIDTH. Operand k occupies bits [k*WIDTH +: WIDTH] of `operands_i`.
- R2: Each compressor computes, for each bit position, the XOR of its three inputs as the sum vector. It computes the majority of the three inputs, shifted up one position with a 0 at bit 0, as the carry vector, and the top majority bit is dropped. For N=3, `pair_a_o` is that sum vector and `pair_b_o` is that carry vector of operands 0, 1 and 2.
- R3: For every N, `pair_a_o + pair_b_o` modulo 2^WIDTH equals the modular sum of all operands.
- R4: With N=0, `pair_a_o`, `pair_b_o` and `total_o` are all zero whatever the input bits are.
- R5: With N=1, `pair_a_o` equals operand 0 and `pair_b_o` is zero.
- R6: With N=2, no compressor is built: `pair_a_o` is operand 0 and `pair_b_o` is operand 1.
- R7: `fa_count_o` equals N-2 for N of 3 or more, and 0 otherwise.
- R8: `depth_o` is the larger depth of the two final vectors. For N = 0 to 9 it is 0,0,0,1,2,3,3,4,4,4.
- R9: `total_o` equals `pair_a_o + pair_b_o` modulo 2^WIDTH.
- R10: Triples are taken in list order, and the outputs of a triple come ahead of any leftovers. For N=4, operands 0, 1 and 2 are compressed first into S and C. The result pair is then the compressor output of (S, C, operand 3).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| operands_i | input | max(N_OPS,1)*WIDTH | Packed operands, operand k at bits [k*WIDTH +: WIDTH] |
| pair_a_o | output | WIDTH | First reduced vector |
| pair_b_o | output | WIDTH | Second reduced vector |
| total_o | output | WIDTH | Modular sum from the final adder |
| depth_o | output | STAT_W | Compressor levels on the longest path (constant) |
| fa_count_o | output | STAT_W | Number of 3:2 compressors built (constant) |

## Verification
The bench builds ten copies of the tree, with N from 0 to 9 at a width of 5 bits, and drives them all from one shared operand bus. The low 15 bits run through every value, so the three-operand tree is covered exhaustively, while the higher operands take random values. This sweep separates correct carry alignment and dropping of the top carry from a missing or wrong shift. All-zero, all-one and single-bit-set patterns stress carries that run the full width and wrap past the top bit. The exact reduced pair is checked for N=3 and N=4, which catches a schedule that groups operands in the wrong order even when the final sum is still right.

// File: rtl/csa_tree_pkg.sv
package csa_tree_pkg;

  localparam int MAX_OPS   = 32;
  localparam int MAX_NODES = 3 * MAX_OPS;

  typedef enum int {Q_COUNT, Q_DEPTH, Q_SRC, Q_FINAL} sched_query_e;

  // Walk the depth-aware schedule for n_ops operands.
  // Node ids: inputs 0..n_ops-1, compressor k -> sum n_ops+2k, carry n_ops+2k+1.
  function automatic int sched_walk(int n_ops, sched_query_e q, int fa_idx, int slot);
    int ops   [MAX_OPS];
    int rdy   [MAX_OPS];
    int wait_l[MAX_OPS];
    int nxt   [MAX_OPS];
    int dep   [MAX_NODES];
    int n_cur, n_rdy, n_wait, n_nxt, n_fa, res, used, d, sid;
    res = -1;
    n_fa = 0;
    for (int i = 0; i < MAX_NODES; i++) dep[i] = 0;
    for (int i = 0; i < MAX_OPS; i++) begin
      ops[i] = (i < n_ops) ? i : 0;
      rdy[i] = 0; wait_l[i] = 0; nxt[i] = 0;
    end
    n_cur = n_ops;
    for (int lvl = 0; (n_cur > 2) && (lvl < 2 * MAX_OPS); lvl++) begin
      n_rdy = 0;
      n_wait = 0;
      for (int i = 0; i < n_cur; i++) begin
        if (dep[ops[i]] <= lvl) begin
          rdy[n_rdy] = ops[i];
          n_rdy = n_rdy + 1;
        end else begin
          wait_l[n_wait] = ops[i];
          n_wait = n_wait + 1;
        end
      end
      if (n_rdy >= 3) begin
        n_nxt = 0;
        used = 0;
        for (int t = 0; 3 * t + 2 < n_rdy; t++) begin
          d = dep[rdy[3*t]];
          if (dep[rdy[3*t+1]] > d) d = dep[rdy[3*t+1]];
          if (dep[rdy[3*t+2]] > d) d = dep[rdy[3*t+2]];
          sid = n_ops + 2 * n_fa;
          if (q == Q_SRC && fa_idx == n_fa) res = rdy[3*t + slot];
          dep[sid]     = d + 1;
          dep[sid + 1] = d + 1;
          nxt[n_nxt]     = sid;
          nxt[n_nxt + 1] = sid + 1;
          n_nxt = n_nxt + 2;
          n_fa  = n_fa + 1;
          used  = 3 * t + 3;
        end
        for (int t = used; t < n_rdy; t++) begin
          nxt[n_nxt] = rdy[t];
          n_nxt = n_nxt + 1;
        end
        for (int t = 0; t < n_wait; t++) begin
          nxt[n_nxt] = wait_l[t];
          n_nxt = n_nxt + 1;
        end
        for (int t = 0; t < n_nxt; t++) ops[t] = nxt[t];
        n_cur = n_nxt;
      end
    end
    case (q)
      Q_COUNT: res = n_fa;
      Q_DEPTH: begin
        res = 0;
        if (n_cur >= 1) res = dep[ops[0]];
        if (n_cur >= 2 && dep[ops[1]] > res) res = dep[ops[1]];
      end
      Q_FINAL: res = (slot < n_cur) ? ops[slot] : -1;
      default: ;
    endcase
    return res;
  endfunction

  function automatic int fa_total(int n_ops);
    return sched_walk(n_ops, Q_COUNT, 0, 0);
  endfunction

  function automatic int tree_depth(int n_ops);
    return sched_walk(n_ops, Q_DEPTH, 0, 0);
  endfunction

  function automatic int fa_src(int n_ops, int k, int slot);
    return sched_walk(n_ops, Q_SRC, k, slot);
  endfunction

  function automatic int final_node(int n_ops, int slot);
    return sched_walk(n_ops, Q_FINAL, 0, slot);
  endfunction

endpackage

// File: rtl/csa_compressor.sv
module csa_compressor #(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH-1:0] in_x,
  input  logic [WIDTH-1:0] in_y,
  input  logic [WIDTH-1:0] in_z,
  output logic [WIDTH-1:0] sum_o,
  output logic [WIDTH-1:0] carry_o
);

  function automatic logic [WIDTH-1:0] vote3(logic [WIDTH-1:0] a, logic [WIDTH-1:0] b,
                                             logic [WIDTH-1:0] c);
    return (a & b) | (a & c) | (b & c);
  endfunction

  logic [WIDTH-1:0] maj_w;

  always_comb begin
    sum_o   = in_x ^ in_y ^ in_z;
    maj_w   = vote3(in_x, in_y, in_z);
    carry_o = {maj_w[WIDTH-2:0], 1'b0};
  end

  always_comb begin
    AST_CSA_CONSERVE: assert (WIDTH'(sum_o + carry_o) == WIDTH'(in_x + in_y + in_z)) // R2
      else $error("compressor pair does not conserve the modular sum");
  end

endmodule

// File: rtl/csa_ripple_add.sv
module csa_ripple_add #(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  output logic [WIDTH-1:0] sum_o
);

  logic [WIDTH-1:0] cin_w;

  assign cin_w[0] = 1'b0;

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    assign sum_o[i] = a_i[i] ^ b_i[i] ^ cin_w[i];
    if (i < WIDTH - 1) begin : g_carry
      assign cin_w[i+1] = (a_i[i] & b_i[i]) | (cin_w[i] & (a_i[i] ^ b_i[i]));
    end
  end

  always_comb begin
    AST_CPA_MATCH: assert (sum_o == WIDTH'(a_i + b_i)) // R9
      else $error("final adder result differs from modular sum of pair");
  end

endmodule

// File: rtl/csa_reduce_tree.sv
module csa_reduce_tree
  import csa_tree_pkg::*;
#(
  parameter int N_OPS  = 7,
  parameter int WIDTH  = 16,
  parameter int STAT_W = 8
) (
  input  logic [((N_OPS > 0) ? N_OPS : 1)*WIDTH-1:0] operands_i,
  output logic [WIDTH-1:0]                            pair_a_o,
  output logic [WIDTH-1:0]                            pair_b_o,
  output logic [WIDTH-1:0]                            total_o,
  output logic [STAT_W-1:0]                           depth_o,
  output logic [STAT_W-1:0]                           fa_count_o
);

  localparam int FA_NUM     = fa_total(N_OPS);
  localparam int DEPTH      = tree_depth(N_OPS);
  localparam int NODE_NUM   = N_OPS + 2 * FA_NUM;
  localparam int NODE_ALLOC = (NODE_NUM > 0) ? NODE_NUM : 1;
  localparam int FIN_A      = final_node(N_OPS, 0);
  localparam int FIN_B      = final_node(N_OPS, 1);

  logic [WIDTH-1:0] node_w [NODE_ALLOC];

  // Operand nodes
  if (N_OPS == 0) begin : g_empty
    assign node_w[0] = '0;
  end else begin : g_inputs
    for (genvar g = 0; g < N_OPS; g++) begin : g_in
      assign node_w[g] = operands_i[g*WIDTH +: WIDTH];
    end
  end

  // Compressor levels, wiring taken from the elaboration-time schedule
  for (genvar k = 0; k < FA_NUM; k++) begin : g_fa
    localparam int SRC_X = fa_src(N_OPS, k, 0);
    localparam int SRC_Y = fa_src(N_OPS, k, 1);
    localparam int SRC_Z = fa_src(N_OPS, k, 2);
    csa_compressor #(.WIDTH(WIDTH)) u_fa (
      .in_x    (node_w[SRC_X]),
      .in_y    (node_w[SRC_Y]),
      .in_z    (node_w[SRC_Z]),
      .sum_o   (node_w[N_OPS + 2*k]),
      .carry_o (node_w[N_OPS + 2*k + 1])
    );
  end

  // Final pair selection (degenerate sizes give zero vectors)
  if (FIN_A >= 0) begin : g_pa
    assign pair_a_o = node_w[FIN_A];
  end else begin : g_pa_zero
    assign pair_a_o = '0;
  end

  if (FIN_B >= 0) begin : g_pb
    assign pair_b_o = node_w[FIN_B];
  end else begin : g_pb_zero
    assign pair_b_o = '0;
  end

  csa_ripple_add #(.WIDTH(WIDTH)) u_cpa (
    .a_i   (pair_a_o),
    .b_i   (pair_b_o),
    .sum_o (total_o)
  );

  assign depth_o    = STAT_W'(DEPTH);
  assign fa_count_o = STAT_W'(FA_NUM);

  // Observation wires for the checks below
  logic [WIDTH-1:0] ref_total_w;
  logic             all_zero_w;

  always_comb begin
    ref_total_w = '0;
    for (int i = 0; i < N_OPS; i++) ref_total_w = WIDTH'(ref_total_w + operands_i[i*WIDTH +: WIDTH]);
    all_zero_w = (operands_i == '0);
  end

  always_comb begin
    AST_PAIR_TOTAL: assert (WIDTH'(pair_a_o + pair_b_o) == ref_total_w) // R3
      else $error("reduced pair lost part of the operand sum");
    AST_SUM_TOTAL: assert (total_o == ref_total_w) // R1
      else $error("final sum differs from modular operand sum");
    AST_ZERO_IN_ZERO_OUT: assert (!all_zero_w || (pair_a_o == '0 && pair_b_o == '0)) // R4
      else $error("zero operands produced a nonzero pair");
  end

endmodule

// File: tb/csa_reduce_tree_test.sv
module csa_reduce_tree_test;

  localparam int CLK_PERIOD = 10;
  localparam int W          = 5;
  localparam int MAXN       = 9;
  localparam int WATCHDOG   = 150000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic [MAXN*W-1:0] stim = '0;

  logic [W-1:0] pa  [0:MAXN];
  logic [W-1:0] pb  [0:MAXN];
  logic [W-1:0] tot [0:MAXN];
  logic [7:0]   dep [0:MAXN];
  logic [7:0]   cnt [0:MAXN];

  for (genvar n = 0; n <= MAXN; n++) begin : g_dut
    csa_reduce_tree #(.N_OPS(n), .WIDTH(W), .STAT_W(8)) uut (
      .operands_i (stim[((n > 0) ? n : 1)*W-1:0]),
      .pair_a_o   (pa[n]),
      .pair_b_o   (pb[n]),
      .total_o    (tot[n]),
      .depth_o    (dep[n]),
      .fa_count_o (cnt[n])
    );
  end

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  task automatic chk(string req, int actual, int expected);
    checks++;
    if (actual != expected) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d (stim %h)", req, actual, expected, stim);
    end
  endtask

  function automatic logic [W-1:0] op(int i);
    return stim[i*W +: W];
  endfunction

  // Bitwise count of ones; low bit is the sum, count >= 2 carries upward
  function automatic logic [W-1:0] c_sum(logic [W-1:0] x, logic [W-1:0] y, logic [W-1:0] z);
    logic [W-1:0] r = '0;
    for (int b = 0; b < W; b++) r[b] = ((int'(x[b]) + int'(y[b]) + int'(z[b])) % 2) == 1;
    return r;
  endfunction

  function automatic logic [W-1:0] c_carry(logic [W-1:0] x, logic [W-1:0] y, logic [W-1:0] z);
    logic [W-1:0] r = '0;
    for (int b = 0; b + 1 < W; b++) r[b+1] = (int'(x[b]) + int'(y[b]) + int'(z[b])) >= 2;
    return r;
  endfunction

  task automatic check_all();
    int acc;
    logic [W-1:0] s1, c1;
    for (int n = 0; n <= MAXN; n++) begin
      acc = 0;
      for (int i = 0; i < n; i++) acc += int'(op(i));
      acc = acc % (1 << W);
      chk("R1", int'(tot[n]), acc);
      chk("R3", (int'(pa[n]) + int'(pb[n])) % (1 << W), acc);
      chk("R9", int'(tot[n]), (int'(pa[n]) + int'(pb[n])) % (1 << W));
    end
    chk("R4", int'(pa[0]), 0);
    chk("R4", int'(pb[0]), 0);
    chk("R4", int'(tot[0]), 0);
    chk("R5", int'(pa[1]), int'(op(0)));
    chk("R5", int'(pb[1]), 0);
    chk("R6", int'(pa[2]), int'(op(0)));
    chk("R6", int'(pb[2]), int'(op(1)));
    chk("R2", int'(pa[3]), int'(c_sum(op(0), op(1), op(2))));
    chk("R2", int'(pb[3]), int'(c_carry(op(0), op(1), op(2))));
    s1 = c_sum(op(0), op(1), op(2));
    c1 = c_carry(op(0), op(1), op(2));
    chk("R10", int'(pa[4]), int'(c_sum(s1, c1, op(3))));
    chk("R10", int'(pb[4]), int'(c_carry(s1, c1, op(3))));
  endtask

  task automatic apply(logic [MAXN*W-1:0] v);
    @(posedge clk);
    stim = v;
    @(negedge clk);
    check_all();
  endtask

  initial begin : watchdog
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin : main
    int exp_depth [0:MAXN] = '{0, 0, 0, 1, 2, 3, 3, 4, 4, 4};
    repeat (3) @(posedge clk);
    @(negedge clk);
    // Reset state: all operands held at zero
    for (int n = 0; n <= MAXN; n++) chk("R1", int'(tot[n]), 0);
    rst = 1'b0;

    // Elaboration constants
    for (int n = 0; n <= MAXN; n++) begin
      chk("R7", int'(cnt[n]), (n > 2) ? n - 2 : 0);
      chk("R8", int'(dep[n]), exp_depth[n]);
    end

    // Corner patterns
    apply('0);
    apply('1);
    for (int b = 0; b < MAXN*W; b++) apply((MAXN*W)'(1) << b);
    apply({MAXN{W'(1)}});
    apply({MAXN{W'((1 << W) - 1)}});

    // Exhaustive low three operands, random upper operands
    for (int v = 0; v < (1 << (3*W)); v++) begin
      logic [MAXN*W-1:0] r;
      r = (MAXN*W)'({$urandom(), $urandom()});
      r[3*W-1:0] = (3*W)'(v);
      apply(r);
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule